// File: doc/BRIEF.md
# Handshaked Parallel Byte Port with Status Word

This peripheral links a processor bus to an external byte-wide device through two one-byte channels. The processor sees two addresses. At `BASE_ADDR` it reads the byte that came in from the device, or writes a byte to be sent out. At `BASE_ADDR + 1` it reads a status word. Three flags live in the status word: input pending, output free and input overrun. Software polls the status word and touches the data address only once the flag it needs is set. A data access clears that flag in hardware, so the driver never has to clear it itself.

On the device side each direction uses valid/ready naming. The inbound channel does not push back. A pulse on `in_valid` is always accepted. `in_ready` only tells the device that the previous byte has been consumed. Sending while it is low overwrites the held byte and records an overrun.

The outbound channel does push back. After a processor write, `out_valid` stays high and `out_data` holds its value until the device asserts `out_ready`. That handshake frees the output slot again.

Top module: `pio_hs_port`

## Requirements
- R1: After reset the status word reads 0x02 (output free, nothing pending, no overrun), `out_valid` is 0 and `in_ready` is 1.
- R2: A read at `BASE_ADDR + 1` returns input-pending in bit 0, output-free in bit 1 and overrun in bit 2, with every other bit 0. Read data for any access appears on `rd_data` in the cycle after `rd_en`, and the flags it reports are their values before that edge.
- R3: A cycle with `in_valid` high captures `in_data` and sets input-pending. `in_ready` is the inverse of input-pending.
- R4: A read at `BASE_ADDR` returns the captured byte and clears input-pending.
- R5: `in_valid` while input-pending is set, with no data read in that cycle, replaces the held byte and sets overrun. Overrun stays set until a status read clears it.
- R6: When a set and a clear of the same flag meet in one cycle, the set wins. This covers `in_valid` together with a data read (input-pending stays set, no overrun) and a new overrun together with a status read (overrun stays set).
- R7: A write at `BASE_ADDR` places `wr_data` on `out_data`, raises `out_valid` and clears output-free.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold. A cycle with both high sets output-free and drops `out_valid`.
- R9: A data write in the same cycle as an output handshake leaves output-free set and `out_valid` low.
- R10: Writes to `BASE_ADDR + 1` and to any address other than the two port addresses change no flag and no output. Reads of other addresses return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Bus address |
| rd_en | input | 1 | Bus read strobe |
| wr_en | input | 1 | Bus write strobe |
| wr_data | input | DATA_W | Bus write data |
| rd_data | output | DATA_W | Bus read data, registered |
| in_valid | input | 1 | Device offers an inbound byte (always accepted) |
| in_data | input | DATA_W | Inbound byte |
| in_ready | output | 1 | Inbound slot empty |
| out_valid | output | 1 | Outbound byte present |
| out_data | output | DATA_W | Outbound byte |
| out_ready | input | 1 | Device takes the outbound byte |

## Verification
The hardest cases to reach are the set-wins collisions. In one, an inbound strobe lands in the same cycle as the processor's data read. In another, a fresh overrun coincides with the status read that would clear the old one. In the third, an output handshake meets a new data write.

Sequential bus tasks never line these up, so the bench has dedicated tasks that drive both sides at the same falling edge. It then reads the status word back to observe which flag survived.

// File: rtl/pio_hs_pkg.sv
package pio_hs_pkg;
  localparam int ST_IRDY = 0;
  localparam int ST_ORDY = 1;
  localparam int ST_OVR  = 2;
  localparam int ST_USED = 3;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_DATA = 2'd1,
    SEL_STAT = 2'd2
  } pio_sel_e;
endpackage

// File: rtl/pio_addr_dec.sv
module pio_addr_dec
  import pio_hs_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h40
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd_en,
  input  logic              wr_en,
  output pio_sel_e          sel,
  output logic              data_rd,
  output logic              data_wr,
  output logic              stat_rd
);
  localparam logic [ADDR_W-1:0] STAT_ADDR = BASE_ADDR + 1'b1;

  always_comb begin
    if (addr == BASE_ADDR)      sel = SEL_DATA;
    else if (addr == STAT_ADDR) sel = SEL_STAT;
    else                        sel = SEL_NONE;
  end

  // status writes decode to nothing: they are dropped here
  assign data_rd = rd_en && (sel == SEL_DATA);
  assign data_wr = wr_en && (sel == SEL_DATA);
  assign stat_rd = rd_en && (sel == SEL_STAT);
endmodule

// File: rtl/pio_in_chan.sv
module pio_in_chan #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe,
  input  logic [DATA_W-1:0] din,
  input  logic              data_rd,
  input  logic              stat_rd,
  output logic              pend,
  output logic              ovr,
  output logic [DATA_W-1:0] hold
);
  logic pend_n, ovr_n;

  always_comb begin
    // set has priority over clear for both flags
    pend_n = strobe ? 1'b1 : (data_rd ? 1'b0 : pend);
    ovr_n  = (strobe && pend && !data_rd) ? 1'b1 : (stat_rd ? 1'b0 : ovr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 1'b0;
      ovr  <= 1'b0;
      hold <= '0;
    end else begin
      pend <= pend_n;
      ovr  <= ovr_n;
      if (strobe) hold <= din;
    end
  end

  p_strobe_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> pend && (hold == $past(din)));
  p_read_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && !strobe) |=> !pend);
  p_ovr_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr && !stat_rd) |=> ovr);
  p_collide_no_ovr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && data_rd && !ovr) |=> (pend && !ovr));
endmodule

// File: rtl/pio_out_chan.sv
module pio_out_chan #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              data_wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              dev_ready,
  output logic              free,
  output logic              valid,
  output logic [DATA_W-1:0] byte_q
);
  logic ack, free_n;

  assign valid  = !free;
  assign ack    = valid && dev_ready;
  assign free_n = ack ? 1'b1 : (data_wr ? 1'b0 : free);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      free   <= 1'b1;
      byte_q <= '0;
    end else begin
      free <= free_n;
      if (data_wr) byte_q <= wdata;
    end
  end

  p_write_loads_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && !ack) |=> valid && (byte_q == $past(wdata)));
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !dev_ready && !data_wr) |=> valid && $stable(byte_q));
  p_ack_frees_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> free);
endmodule

// File: rtl/pio_hs_port.sv
module pio_hs_port
  import pio_hs_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  input  logic              out_ready
);
  localparam logic [ADDR_W-1:0] STAT_ADDR = BASE_ADDR + 1'b1;

  pio_sel_e          sel;
  logic              data_rd, data_wr, stat_rd;
  logic              pend, ovr, free;
  logic [DATA_W-1:0] in_hold;
  logic [DATA_W-1:0] stat_word;

  pio_addr_dec #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_dec (
    .addr(addr), .rd_en(rd_en), .wr_en(wr_en), .sel(sel),
    .data_rd(data_rd), .data_wr(data_wr), .stat_rd(stat_rd)
  );

  pio_in_chan #(.DATA_W(DATA_W)) u_in (
    .clk(clk), .rst_n(rst_n), .strobe(in_valid), .din(in_data),
    .data_rd(data_rd), .stat_rd(stat_rd), .pend(pend), .ovr(ovr),
    .hold(in_hold)
  );

  pio_out_chan #(.DATA_W(DATA_W)) u_out (
    .clk(clk), .rst_n(rst_n), .data_wr(data_wr), .wdata(wr_data),
    .dev_ready(out_ready), .free(free), .valid(out_valid),
    .byte_q(out_data)
  );

  assign in_ready = !pend;

  // assemble status word; unused upper bits tie to zero
  genvar gi;
  generate
    for (gi = 0; gi < DATA_W; gi++) begin : g_stat
      if (gi == ST_IRDY)      begin : g_i assign stat_word[gi] = pend; end
      else if (gi == ST_ORDY) begin : g_o assign stat_word[gi] = free; end
      else if (gi == ST_OVR)  begin : g_v assign stat_word[gi] = ovr;  end
      else                    begin : g_z assign stat_word[gi] = 1'b0; end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
    end else if (rd_en) begin
      unique case (sel)
        SEL_DATA: rd_data <= in_hold;
        SEL_STAT: rd_data <= stat_word;
        default:  rd_data <= '0;
      endcase
    end
  end

  p_stat_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == STAT_ADDR) |=> (rd_data[DATA_W-1:ST_USED] == '0));
  p_stat_wr_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == STAT_ADDR && !(out_valid && out_ready))
      |=> $stable(out_valid) && $stable(out_data));
  p_stray_rd_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr != BASE_ADDR && addr != STAT_ADDR) |=> (rd_data == '0));
endmodule

// File: tb/pio_hs_port_test.sv
module pio_hs_port_test;
  localparam logic [7:0] BASE = 8'h40;
  localparam logic [7:0] STAT = 8'h41;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] addr = '0;
  logic       rd_en = 1'b0, wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic       in_ready, out_valid, out_ready = 1'b0;
  logic [7:0] out_data;
  int n_chk = 0, n_fail = 0;
  logic [7:0] v;

  always #4 clk = ~clk;

  pio_hs_port #(.ADDR_W(8), .DATA_W(8), .BASE_ADDR(BASE)) uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .in_valid(in_valid),
    .in_data(in_data), .in_ready(in_ready), .out_valid(out_valid),
    .out_data(out_data), .out_ready(out_ready)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; d = rd_data;
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic push(input logic [7:0] d);
    @(negedge clk); in_valid = 1'b1; in_data = d;
    @(negedge clk); in_valid = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 out_valid", {7'd0, out_valid}, 8'h00);
    check("R1 in_ready", {7'd0, in_ready}, 8'h01);
    bus_rd(STAT, v); check("R1 status", v, 8'h02);
  endtask

  task automatic t_input;
    push(8'hA5);
    check("R3 in_ready low", {7'd0, in_ready}, 8'h00);
    bus_rd(STAT, v); check("R2 R3 status pending", v, 8'h03);
    bus_rd(BASE, v); check("R4 data", v, 8'hA5);
    bus_rd(STAT, v); check("R4 cleared", v, 8'h02);
  endtask

  task automatic t_overrun;
    push(8'h11); push(8'h22);
    bus_rd(STAT, v); check("R5 overrun", v, 8'h07);
    bus_rd(STAT, v); check("R5 overrun cleared by status read", v, 8'h03);
    bus_rd(BASE, v); check("R5 newest byte", v, 8'h22);
  endtask

  task automatic t_collide_in;
    push(8'h33);
    @(negedge clk); addr = BASE; rd_en = 1'b1; in_valid = 1'b1; in_data = 8'h44;
    @(negedge clk); rd_en = 1'b0; in_valid = 1'b0; v = rd_data;
    check("R6 read old byte", v, 8'h33);
    bus_rd(STAT, v); check("R6 pending kept, no overrun", v, 8'h03);
    bus_rd(BASE, v); check("R6 new byte", v, 8'h44);
    push(8'h55);
    @(negedge clk); addr = STAT; rd_en = 1'b1; in_valid = 1'b1; in_data = 8'h66;
    @(negedge clk); rd_en = 1'b0; in_valid = 1'b0; v = rd_data;
    check("R6 status before edge", v, 8'h03);
    bus_rd(STAT, v); check("R6 overrun wins over clear", v, 8'h07);
    bus_rd(BASE, v); check("R6 drained", v, 8'h66);
    bus_rd(STAT, v); check("R6 idle", v, 8'h02);
  endtask

  task automatic t_output;
    bus_wr(BASE, 8'hC3);
    check("R7 out_valid", {7'd0, out_valid}, 8'h01);
    check("R7 out_data", out_data, 8'hC3);
    bus_rd(STAT, v); check("R7 status busy", v, 8'h00);
    repeat (3) @(negedge clk);
    check("R8 held valid", {7'd0, out_valid}, 8'h01);
    check("R8 held data", out_data, 8'hC3);
    out_ready = 1'b1; @(negedge clk); out_ready = 1'b0;
    check("R8 ack drops valid", {7'd0, out_valid}, 8'h00);
    bus_rd(STAT, v); check("R8 free again", v, 8'h02);
  endtask

  task automatic t_collide_out;
    bus_wr(BASE, 8'h5A);
    @(negedge clk); addr = BASE; wr_en = 1'b1; wr_data = 8'h77; out_ready = 1'b1;
    @(negedge clk); wr_en = 1'b0; out_ready = 1'b0;
    check("R9 valid low", {7'd0, out_valid}, 8'h00);
    bus_rd(STAT, v); check("R9 free wins", v, 8'h02);
  endtask

  task automatic t_ignored;
    push(8'h99);
    bus_wr(STAT, 8'hFF);
    bus_rd(STAT, v); check("R10 status write ignored", v, 8'h03);
    check("R10 no output from status write", {7'd0, out_valid}, 8'h00);
    bus_wr(BASE + 8'd5, 8'h12);
    check("R10 stray write ignored", {7'd0, out_valid}, 8'h00);
    bus_rd(BASE + 8'd2, v); check("R10 stray read zero", v, 8'h00);
    bus_rd(BASE, v); check("R10 data intact", v, 8'h99);
  endtask

  initial begin
    #(200000 * 8);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_input();
    t_overrun();
    t_collide_in();
    t_output();
    t_collide_out();
    t_ignored();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule